// File: doc/BRIEF.md
# Packed Ternary-Weight Dot-Product Engine

This block forms dot products between signed 8-bit activation vectors and weight vectors whose elements are limited to -1, 0 and +1. Weights arrive as bytes, each holding four 2-bit codes. Activations arrive as four-lane words, one word paired with each weight byte. Each code chooses one action for its lane: pass the activation, pass its negation, or drop it. Because of this the datapath has no multiplier. It is built from per-lane sign selection, a small adder tree and one wide signed accumulator.

A vector is streamed as a run of beats. A beat is taken in any cycle where the weight stream and the activation stream are both valid. A start pulse opens a new vector, and an end-of-vector flag marks its last beat. One cycle after that last beat the finished sum appears with a single-cycle valid pulse, and the accumulator is already empty for the next vector. Scaling of the integer result is left to logic downstream.

Top module: `tern_dot_engine`

## Requirements
- R1: After reset, `sum_o` is 0, `sum_valid_o` is 0 and `code_err_o` is 0.
- R2: Weight lane i sits in `w_byte_i[2i+1:2i]` and pairs with activation lane i in `a_vec_i[8i+7:8i]`. Code 2'b01 adds the activation, code 2'b10 subtracts it and code 2'b00 contributes nothing.
- R3: Code 2'b11 contributes nothing to the sum. It sets `code_err_o`, which stays set across later beats and vectors until a start pulse clears it.
- R4: A beat counts only in a cycle where `w_valid_i` and `a_valid_i` are both high. In any other cycle the weight data, activation data and `eov_i` have no effect.
- R5: `start_i` empties the accumulator and clears `code_err_o`. A beat taken in the same cycle is the first element of the new vector, and an unused code in that beat sets the flag again.
- R6: When a beat with `eov_i` high is taken, the sum that includes this beat appears on `sum_o` in the next cycle, and `sum_valid_o` is high for exactly that one cycle. `sum_o` then keeps its value until the next result.
- R7: After an end-of-vector beat, the next vector starts from zero even when no start pulse is given, so vectors can be sent back to back with no gap.
- R8: Sums are exact 24-bit two's-complement values for any vector of up to 16383 beats (65532 elements), including the cases where every term is +128 or every term is -128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Opens a new vector: empties the accumulator and clears the error flag |
| w_valid_i | input | 1 | Weight byte is valid |
| w_byte_i | input | 8 | Four packed 2-bit weight codes |
| a_valid_i | input | 1 | Activation word is valid |
| a_vec_i | input | 32 | Four signed 8-bit activations |
| eov_i | input | 1 | The current beat is the last one of the vector |
| sum_o | output | 24 | Signed dot-product result |
| sum_valid_o | output | 1 | Single-cycle pulse when `sum_o` carries a new result |
| code_err_o | output | 1 | Sticky flag: an unused weight code has been seen |

## Verification
The assertions assume that `start_i`, both valid inputs and `eov_i` are free of X once reset is released. They also assume that a vector never runs longer than the R8 limit, because a longer run could wrap the accumulator.

The bench drives every input at the falling edge and returns all control inputs to low between scenarios. Its longest vector stays exactly at the R8 limit. The stall cycles it drives put data on one stream at a time, so no beat is taken while the other stream is still invalid.

// File: rtl/tern_pkg.sv
// Shared types for the ternary dot-product engine.
// Assumes a 2-bit code per weight.
package tern_pkg;

    // 2-bit weight code values
    typedef enum logic [1:0] {
        WC_ZERO  = 2'b00,
        WC_PLUS  = 2'b01,
        WC_MINUS = 2'b10,
        WC_RSVD  = 2'b11
    } wcode_e;

    // Decoded action for one lane
    typedef struct packed {
        logic add;
        logic sub;
        logic bad;
    } lane_act_t;

    // Turn a raw code into a lane action; the unused code acts as zero
    function automatic lane_act_t decode_code(input logic [1:0] code);
        lane_act_t act;
        act = '0;
        case (wcode_e'(code))
            WC_PLUS:  act.add = 1'b1;
            WC_MINUS: act.sub = 1'b1;
            WC_RSVD:  act.bad = 1'b1;
            default:  act = '0;
        endcase
        return act;
    endfunction

endpackage

// File: rtl/tern_lane_term.sv
// One lane: maps an activation and a 2-bit weight code to +x, -x or 0.
// The result is one bit wider than the activation so that -(-128) fits.
// Assumes a two's-complement activation.
module tern_lane_term #(
    parameter int ACT_W = 8
) (
    input  logic [ACT_W-1:0] act_i,
    input  logic [1:0]       code_i,
    output logic [ACT_W:0]   term_o,
    output logic             bad_o
);
    import tern_pkg::*;

    lane_act_t        act_s;
    logic [ACT_W:0]   ext_s;
    logic [ACT_W:0]   neg_s;

    // Sign-extend the activation and form its negation
    always_comb begin
        ext_s = {act_i[ACT_W-1], act_i};
        neg_s = (~ext_s) + {{ACT_W{1'b0}}, 1'b1};
    end

    // Pick the lane term from the decoded action
    always_comb begin
        act_s = decode_code(code_i);
        bad_o = act_s.bad;
        if (act_s.add)
            term_o = ext_s;
        else if (act_s.sub)
            term_o = neg_s;
        else
            term_o = '0;
    end

endmodule

// File: rtl/tern_beat_adder.sv
// Adds the lane terms of one beat into one signed beat sum.
// It also reports whether any lane held the unused code.
// Assumes that lane i uses code bits [2i+1:2i] and activation bits [ACT_W*i +: ACT_W].
module tern_beat_adder #(
    parameter int LANES = 4,
    parameter int ACT_W = 8,
    localparam int SUM_W = ACT_W + 1 + $clog2(LANES)
) (
    input  logic [2*LANES-1:0]     w_byte_i,
    input  logic [LANES*ACT_W-1:0] a_vec_i,
    output logic [SUM_W-1:0]       beat_sum_o,
    output logic                   beat_bad_o
);
    logic [ACT_W:0] terms_s [LANES];
    logic [LANES-1:0] bad_s;

    // One term unit per lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tern_lane_term #(.ACT_W(ACT_W)) term_i (
            .act_i  (a_vec_i[g*ACT_W +: ACT_W]),
            .code_i (w_byte_i[2*g +: 2]),
            .term_o (terms_s[g]),
            .bad_o  (bad_s[g])
        );
    end

    // Sign-extend every lane term and sum them
    always_comb begin
        beat_sum_o = '0;
        for (int i = 0; i < LANES; i++) begin
            beat_sum_o = beat_sum_o
                + {{(SUM_W-ACT_W-1){terms_s[i][ACT_W]}}, terms_s[i]};
        end
    end

    // Flag a beat that holds any unused code
    always_comb beat_bad_o = |bad_s;

endmodule

// File: rtl/tern_accum.sv
// Vector accumulator: adds the beat sums, publishes the total after the
// last beat and empties itself for the next vector.
// Assumes that fire_i is high only when a beat is actually taken.
module tern_accum #(
    parameter int ACC_W = 24,
    parameter int SUM_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             fire_i,
    input  logic             last_i,
    input  logic [SUM_W-1:0] beat_sum_i,
    input  logic             beat_bad_i,
    output logic [ACC_W-1:0] sum_o,
    output logic             sum_valid_o,
    output logic             err_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] base_s;
    logic [ACC_W-1:0] next_s;

    // Running total including the current beat; start drops the old total
    always_comb begin
        base_s = start_i ? '0 : acc_q;
        next_s = base_s + {{(ACC_W-SUM_W){beat_sum_i[SUM_W-1]}}, beat_sum_i};
    end

    // Accumulator register: grows on each beat and clears after the last one
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (fire_i && last_i)
            acc_q <= '0;
        else if (fire_i)
            acc_q <= next_s;
        else if (start_i)
            acc_q <= '0;
    end

    // Result register: captures the final total
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_o <= '0;
        else if (fire_i && last_i)
            sum_o <= next_s;
    end

    // Result strobe: one cycle after the last beat
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_valid_o <= 1'b0;
        else
            sum_valid_o <= fire_i && last_i;
    end

    // Sticky flag for the unused code; start clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= 1'b0;
        else if (fire_i && beat_bad_i)
            err_o <= 1'b1;
        else if (start_i)
            err_o <= 1'b0;
    end

endmodule

// File: rtl/tern_dot_engine.sv
// Top of the packed ternary-weight dot-product engine. Takes one weight
// byte and one multi-lane activation word per beat and adds them with no
// multiplier.
// Assumes that vectors stay within the length the accumulator can hold.
module tern_dot_engine #(
    parameter int LANES = 4,
    parameter int ACT_W = 8,
    parameter int ACC_W = 24,
    localparam int SUM_W = ACT_W + 1 + $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   w_valid_i,
    input  logic [2*LANES-1:0]     w_byte_i,
    input  logic                   a_valid_i,
    input  logic [LANES*ACT_W-1:0] a_vec_i,
    input  logic                   eov_i,
    output logic [ACC_W-1:0]       sum_o,
    output logic                   sum_valid_o,
    output logic                   code_err_o
);
    logic             fire_s;
    logic [SUM_W-1:0] beat_sum_s;
    logic             beat_bad_s;

    // A beat is taken only when both streams are valid
    always_comb fire_s = w_valid_i && a_valid_i;

    tern_beat_adder #(.LANES(LANES), .ACT_W(ACT_W)) adder_i (
        .w_byte_i   (w_byte_i),
        .a_vec_i    (a_vec_i),
        .beat_sum_o (beat_sum_s),
        .beat_bad_o (beat_bad_s)
    );

    tern_accum #(.ACC_W(ACC_W), .SUM_W(SUM_W)) accum_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .fire_i      (fire_s),
        .last_i      (eov_i),
        .beat_sum_i  (beat_sum_s),
        .beat_bad_i  (beat_bad_s),
        .sum_o       (sum_o),
        .sum_valid_o (sum_valid_o),
        .err_o       (code_err_o)
    );

endmodule

// File: rtl/tern_dot_engine_chk.sv
// Protocol and state checks for tern_dot_engine, bound to every instance.
module tern_dot_engine_chk #(
    parameter int LANES = 4,
    parameter int ACT_W = 8,
    parameter int ACC_W = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   w_valid_i,
    input logic [2*LANES-1:0]     w_byte_i,
    input logic                   a_valid_i,
    input logic [LANES*ACT_W-1:0] a_vec_i,
    input logic                   eov_i,
    input logic [ACC_W-1:0]       sum_o,
    input logic                   sum_valid_o,
    input logic                   code_err_o
);
    logic take_s;
    always_comb take_s = w_valid_i && a_valid_i;

    AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (take_s && eov_i) |=> sum_valid_o); // R6
    AST_VALID_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sum_valid_o) |-> $past(take_s && eov_i)); // R4
    AST_SUM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sum_valid_o |-> $stable(sum_o)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (code_err_o && !start_i) |=> code_err_o); // R3
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_err_o) |-> $past(take_s)); // R3
    AST_START_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !take_s) |=> !code_err_o); // R5
    AST_ZERO_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && take_s && eov_i && (w_byte_i == '0)) |=> (sum_o == '0)); // R2

endmodule

bind tern_dot_engine tern_dot_engine_chk #(
    .LANES(LANES), .ACT_W(ACT_W), .ACC_W(ACC_W)
) chk_i (.*);

// File: tb/tern_dot_engine_tb_top.sv
// Directed bench for tern_dot_engine: one task per scenario.
module tern_dot_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        w_valid_i = 1'b0;
    logic [7:0]  w_byte_i = '0;
    logic        a_valid_i = 1'b0;
    logic [31:0] a_vec_i = '0;
    logic        eov_i = 1'b0;
    logic [23:0] sum_o;
    logic        sum_valid_o;
    logic        code_err_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    tern_dot_engine dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .w_valid_i(w_valid_i), .w_byte_i(w_byte_i),
        .a_valid_i(a_valid_i), .a_vec_i(a_vec_i), .eov_i(eov_i),
        .sum_o(sum_o), .sum_valid_o(sum_valid_o), .code_err_o(code_err_o)
    );

    // Expected beat value worked out from the code map
    function automatic int ref_beat(input logic [7:0] w, input logic [31:0] a);
        int s = 0;
        for (int i = 0; i < 4; i++) begin
            int x = int'($signed(a[8*i +: 8]));
            case (w[2*i +: 2])
                2'b01: s = s + x;
                2'b10: s = s - x;
                default: s = s + 0;
            endcase
        end
        return s;
    endfunction

    function automatic logic [31:0] pack4(input int a0, input int a1, input int a2, input int a3);
        return {a3[7:0], a2[7:0], a1[7:0], a0[7:0]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sum_now();
        return int'($signed(sum_o));
    endfunction

    // Drive one cycle of inputs at the falling edge; returns 1 ns after the rising edge
    task automatic drive(input bit st, input bit wv, input bit av,
                         input logic [7:0] w, input logic [31:0] a, input bit last);
        @(negedge clk);
        start_i = st; w_valid_i = wv; a_valid_i = av;
        w_byte_i = w; a_vec_i = a; eov_i = last;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(0, 0, 0, 8'h00, 32'h0, 0);
    endtask

    task automatic t_reset();
        chk("R1 sum", sum_now(), 0);
        chk("R1 valid", int'(sum_valid_o), 0);
        chk("R1 err", int'(code_err_o), 0);
    endtask

    // R2: lane placement and the three codes
    task automatic t_lanes();
        logic [31:0] a = pack4(5, -7, 100, -128);
        logic [7:0] ws [4] = '{8'b00_00_00_01, 8'b00_00_10_00, 8'b01_10_00_00, 8'b10_01_10_01};
        for (int k = 0; k < 4; k++) begin
            drive(1, 1, 1, ws[k], a, 1);
            chk("R2 valid", int'(sum_valid_o), 1);
            chk("R2 lane sum", sum_now(), ref_beat(ws[k], a));
        end
        idle();
        chk("R6 single pulse", int'(sum_valid_o), 0);
    endtask

    // R3: the unused code adds nothing and latches the flag
    task automatic t_unused();
        logic [31:0] a = pack4(10, 20, 30, 40);
        drive(1, 1, 1, 8'b11_01_11_01, a, 1);
        chk("R3 sum ignores 11", sum_now(), 40);
        chk("R3 err set", int'(code_err_o), 1);
        drive(0, 1, 1, 8'b01_01_01_01, a, 1);
        chk("R3 err sticky", int'(code_err_o), 1);
        chk("R7 next vector", sum_now(), 100);
        drive(1, 0, 0, 8'h00, 32'h0, 0);
        chk("R5 start clears err", int'(code_err_o), 0);
        idle();
    endtask

    // R4: half-valid cycles take no beat
    task automatic t_stall();
        logic [31:0] a = pack4(1, 2, 3, 4);
        drive(1, 1, 1, 8'b01_01_01_01, a, 0);
        drive(0, 1, 0, 8'b01_01_01_01, pack4(127, 127, 127, 127), 1);
        chk("R4 no result on w only", int'(sum_valid_o), 0);
        drive(0, 0, 1, 8'b11_11_11_11, pack4(99, 99, 99, 99), 1);
        chk("R4 no result on a only", int'(sum_valid_o), 0);
        chk("R4 no err from stall", int'(code_err_o), 0);
        drive(0, 1, 1, 8'b10_00_00_00, a, 1);
        chk("R4 stalls skipped", sum_now(), 10 - 4);
        idle();
    endtask

    // R5: start mid-vector drops the old total and keeps its own beat
    task automatic t_restart_mid();
        logic [31:0] a = pack4(50, 50, 50, 50);
        drive(1, 1, 1, 8'b01_01_01_01, a, 0);
        drive(0, 1, 1, 8'b01_01_01_01, a, 0);
        drive(1, 1, 1, 8'b00_00_01_10, pack4(3, 9, 0, 0), 0);
        drive(0, 1, 1, 8'b00_00_00_01, pack4(-20, 0, 0, 0), 1);
        chk("R5 start with beat", sum_now(), -3 + 9 - 20);
        idle();
    endtask

    // R6 and R7: back-to-back vectors and holding of the result
    task automatic t_back_to_back();
        logic [31:0] a = pack4(-1, 2, -3, 4);
        drive(1, 1, 1, 8'b01_01_01_01, a, 0);
        drive(0, 1, 1, 8'b01_01_01_01, a, 1);
        chk("R6 first", sum_now(), 4);
        drive(0, 1, 1, 8'b10_10_10_10, a, 1);
        chk("R7 no start needed", sum_now(), -2);
        chk("R6 valid again", int'(sum_valid_o), 1);
        idle();
        idle();
        chk("R6 held", sum_now(), -2);
        chk("R6 pulse ended", int'(sum_valid_o), 0);
    endtask

    // R8: the longest vectors with the largest terms of either sign
    task automatic t_long();
        logic [31:0] a = pack4(-128, -128, -128, -128);
        drive(1, 1, 1, 8'hAA, a, 0);
        for (int k = 1; k < 16383; k++) drive(0, 1, 1, 8'hAA, a, k == 16382);
        chk("R8 max positive", sum_now(), 16383 * 512);
        for (int k = 0; k < 16383; k++) drive(0, 1, 1, 8'h55, a, k == 16382);
        chk("R8 max negative", sum_now(), -16383 * 512);
        idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_lanes();
        t_unused();
        t_stall();
        t_restart_mid();
        t_back_to_back();
        t_long();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule